// File: doc/BRIEF.md
# Sleep-State LED Blink Controller

This block drives an active-low, open-drain indicator LED from a 2-bit mode field and a flag that is true while the system sits in one of the two deepest sleep states. Its only output is a drive-low enable. When the enable is high the pad pulls the LED pin low and the LED lights. When the enable is low the pin floats. Register access and the pad itself live outside the block.

A slow reference tick, such as a 1 kHz strobe from a prescaler, advances an internal phase counter. In blink mode the counter divides the tick into a fixed period, and the first part of each period pulls the pin low. With the default parameters and a 1 kHz tick the period is 1000 ticks and 100 of them pull low, which gives a 1 Hz blink at a 10% duty cycle. The steady-on mode holds the pin low. Both modes take effect only during deep sleep. The mode and sleep inputs pass through one register stage, and the drive enable is registered.

Top module: `sleep_led_ctrl`

## Requirements
- R1: While rst_ni is low, and after its release until a new mode has been registered, led_pull_o is 0 and the mode is taken as 2'b00.
- R2: Mode 2'b00 (off) never asserts led_pull_o.
- R3: Mode 2'b01 (dark) never asserts led_pull_o.
- R4: Mode 2'b11 (steady) asserts led_pull_o continuously while deep_sleep_i is 1.
- R5: While deep_sleep_i is 0, led_pull_o is 0 in every mode.
- R6: Mode 2'b10 (blink) with deep_sleep_i at 1 repeats a period of PERIOD_TICKS ticks of tick_i. led_pull_o is 1 during the first LOW_TICKS ticks of each period and 0 for the rest.
- R7: When blink mode becomes active, either because mode 2'b10 is entered or because deep sleep begins in that mode, the period restarts at the beginning of its low phase.
- R8: A change on mode_i or deep_sleep_i reaches led_pull_o two rising clock edges later.
- R9: The blink phase advances only on clock edges where tick_i is 1. Without ticks, led_pull_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference tick, one clock wide per tick |
| mode_i | input | 2 | LED mode: 00 off, 01 dark, 10 blink, 11 steady |
| deep_sleep_i | input | 1 | High while in either of the two deepest sleep states |
| led_pull_o | output | 1 | Drive-low enable for the open-drain LED pin (1 = pull low) |

## Verification
The bench runs the blink mode with a tick on every clock and checks that the low phase is exactly LOW_TICKS long. A counter that is off by one would show 99 or 101 low cycles. It leaves blink mode in the middle of a period and comes back. A design that resumes the old phase, instead of restarting it, would leave the pin floating where a low phase is expected. It stops the tick during a low phase, which catches a counter that advances on the clock instead of the tick. Random segments that change the mode and the sleep flag are checked on every cycle against a two-stage model. These catch a pull while awake, a pull in the off or dark modes, and a wrong latency.

// File: rtl/sleep_led_pkg.sv
package sleep_led_pkg;
  typedef enum logic [1:0] {
    LED_OFF   = 2'b00,
    LED_DARK  = 2'b01,
    LED_BLINK = 2'b10,
    LED_ON    = 2'b11
  } led_mode_e;
endpackage

// File: rtl/led_mode_reg.sv
module led_mode_reg
  import sleep_led_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       deep_sleep_i,
  output led_mode_e  mode_o,
  output logic       sleep_o,
  output logic       blink_act_o
);
  led_mode_e mode_q;
  logic      sleep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= LED_OFF;
      sleep_q <= 1'b0;
    end else begin
      mode_q  <= led_mode_e'(mode_i);
      sleep_q <= deep_sleep_i;
    end
  end

  assign mode_o      = mode_q;
  assign sleep_o     = sleep_q;
  assign blink_act_o = sleep_q && (mode_q == LED_BLINK);

  assert_mode_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mode_q == led_mode_e'($past(mode_i))));
endmodule

// File: rtl/blink_phase_counter.sv
module blink_phase_counter #(
  parameter int unsigned PERIOD_TICKS = 1000,
  parameter int unsigned LOW_TICKS    = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  output logic low_phase_o
);
  localparam int unsigned CNT_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);
  localparam logic [CNT_W-1:0] LOW  = CNT_W'(LOW_TICKS);

  logic [CNT_W-1:0] cnt_q;

  // Counter sits at zero while idle so activation starts a fresh low phase.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign low_phase_o = (cnt_q < LOW);

  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_idle_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  assert_hold_no_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/led_drive_sel.sv
module led_drive_sel
  import sleep_led_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  led_mode_e mode_i,
  input  logic      sleep_i,
  input  logic      low_phase_i,
  output logic      led_pull_o
);
  logic pull_d;

  always_comb begin
    pull_d = 1'b0;
    if (sleep_i) begin
      unique case (mode_i)
        LED_ON:    pull_d = 1'b1;
        LED_BLINK: pull_d = low_phase_i;
        default:   pull_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) led_pull_o <= 1'b0;
    else         led_pull_o <= pull_d;
  end

  assert_awake_float_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |=> !led_pull_o);
  assert_off_float_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == LED_OFF) |=> !led_pull_o);
  assert_dark_float_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == LED_DARK) |=> !led_pull_o);
  assert_steady_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && mode_i == LED_ON) |=> led_pull_o);
endmodule

// File: rtl/sleep_led_ctrl.sv
module sleep_led_ctrl
  import sleep_led_pkg::*;
#(
  parameter int unsigned PERIOD_TICKS = 1000,
  parameter int unsigned LOW_TICKS    = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  input  logic       deep_sleep_i,
  output logic       led_pull_o
);
  led_mode_e mode_q;
  logic      sleep_q;
  logic      blink_act;
  logic      low_phase;

  led_mode_reg u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .deep_sleep_i (deep_sleep_i),
    .mode_o       (mode_q),
    .sleep_o      (sleep_q),
    .blink_act_o  (blink_act)
  );

  blink_phase_counter #(
    .PERIOD_TICKS (PERIOD_TICKS),
    .LOW_TICKS    (LOW_TICKS)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .run_i       (blink_act),
    .low_phase_o (low_phase)
  );

  led_drive_sel u_drv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_q),
    .sleep_i     (sleep_q),
    .low_phase_i (low_phase),
    .led_pull_o  (led_pull_o)
  );

  initial begin
    assert_params_R6: assert (LOW_TICKS <= PERIOD_TICKS && PERIOD_TICKS > 1);
  end
endmodule

// File: tb/sleep_led_ctrl_test.sv
module sleep_led_ctrl_test;
  localparam int PERIOD = 1000;
  localparam int LOWT   = 100;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       deep_sleep_i = 1'b0;
  logic       led_pull_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // cycle model state
  logic [1:0] m_mode = 2'b00;
  logic       m_sleep = 1'b0;
  int         m_cnt = 0;
  logic       m_out = 1'b0;
  bit         model_on = 0;

  sleep_led_ctrl #(.PERIOD_TICKS(PERIOD), .LOW_TICKS(LOWT)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .mode_i(mode_i), .deep_sleep_i(deep_sleep_i), .led_pull_o(led_pull_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic logic exp_pull(logic [1:0] md, logic sl, int c);
    if (!sl) return 1'b0;
    if (md == 2'b11) return 1'b1;
    if (md == 2'b10) return (c < LOWT);
    return 1'b0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode <= 2'b00; m_sleep <= 1'b0; m_cnt <= 0; m_out <= 1'b0;
    end else begin
      m_out <= exp_pull(m_mode, m_sleep, m_cnt);
      if (!(m_sleep && m_mode == 2'b10)) m_cnt <= 0;
      else if (tick_i) m_cnt <= (m_cnt == PERIOD - 1) ? 0 : m_cnt + 1;
      m_mode  <= mode_i;
      m_sleep <= deep_sleep_i;
    end
  end

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: led_pull_o=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (model_on && rst_ni) begin
      string tag;
      if (!m_sleep) tag = "R5";
      else case (m_mode)
        2'b00: tag = "R2";
        2'b01: tag = "R3";
        2'b11: tag = "R4";
        default: tag = "R6";
      endcase
      check(tag, led_pull_o, m_out);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    int pulls;
    void'($urandom(32'd20240611));
    step(3);
    check("R1", led_pull_o, 1'b0);
    mode_i = 2'b11; deep_sleep_i = 1'b1;
    step(1);
    rst_ni = 1'b1;
    check("R1", led_pull_o, 1'b0);
    model_on = 1;
    step(1);
    check("R1", led_pull_o, 1'b0);
    step(1);
    check("R4", led_pull_o, 1'b1);

    // R8: latency from sleep entry
    deep_sleep_i = 1'b0; step(3);
    deep_sleep_i = 1'b1; step(1);
    check("R8", led_pull_o, 1'b0);
    step(1);
    check("R8", led_pull_o, 1'b1);

    // R6/R7: blink with tick every clock, from dark mode
    mode_i = 2'b01; tick_i = 1'b1; step(4);
    mode_i = 2'b10;
    pulls = 0;
    for (int i = 0; i < PERIOD; i++) begin step(1); pulls += led_pull_o; end
    check_int("R6", pulls, LOWT);
    step(500);
    check("R6", led_pull_o, 1'b0);
    // leave mid-period and return: phase must restart
    mode_i = 2'b01; step(3);
    mode_i = 2'b10; step(2);
    check("R7", led_pull_o, 1'b1);
    pulls = 0;
    for (int i = 0; i < PERIOD; i++) begin pulls += led_pull_o; step(1); end
    check_int("R7", pulls, LOWT);
    // sleep exit/entry restarts too
    step(300);
    deep_sleep_i = 1'b0; step(3);
    deep_sleep_i = 1'b1; step(2);
    check("R7", led_pull_o, 1'b1);

    // R9: stop the tick inside a low phase
    tick_i = 1'b0; step(300);
    check("R9", led_pull_o, 1'b1);
    tick_i = 1'b1; step(LOWT + 5);
    tick_i = 1'b0; step(300);
    check("R9", led_pull_o, 1'b0);

    // random segments
    for (int s = 0; s < 40; s++) begin
      int len;
      mode_i = 2'($urandom_range(0, 3));
      deep_sleep_i = ($urandom_range(0, 3) != 0);
      len = $urandom_range(20, 2500);
      for (int i = 0; i < len; i++) begin
        tick_i = ($urandom_range(0, 1) == 1);
        step(1);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, got=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule